// File: doc/BRIEF.md
# Byte-Lane Bank Select Generator

This block sits between a processor with a 32-bit data path and a memory or I/O space built from four independent 8-bit banks. Each cycle it takes one request, made up of a byte address, a transfer size (byte, halfword or word), a read/write flag and a memory/I/O flag. It works out which banks take part in the transfer and raises the enable for each of those banks.

For writes, the block replicates the low-order processor bytes across the lanes so that every enabled bank sees its own byte. For reads, it collects the bytes from the selected banks and right-aligns them on the processor lanes, filling the unused upper bits with zeros. A request whose address does not suit its size raises an error and touches no bank.

I/O ports follow the same rule as memory. Every port is eight bits wide, and a wider port is a run of consecutive byte ports. For each accepted I/O request the block reports the last port address in the run. It also flags whether the run can be reached with the short 8-bit port number.

The block registers each request once, on the rising clock edge. All outputs are derived from that registered request.

Top module: `lane_sel_top`

## Requirements
- R1: While reset is high and in the first cycle after it, before any request is accepted, bank_en, bank_wdata, cpu_rdata, align_err, io_last_port and io_fixed_ok are all zero.
- R2: A byte request (size code 0) enables exactly one bank, the one numbered by address bits 1..0.
- R3: A halfword request (size code 1) at offset 0 enables banks 0 and 1 (bank_en = 0011b). At offset 2 it enables banks 2 and 3 (1100b).
- R4: A word request (size code 2) at offset 0 enables all four banks (bank_en = 1111b).
- R5: A valid request that is misaligned raises align_err and leaves bank_en at zero. Misaligned means a halfword at an odd address, a word with nonzero address bits 1..0, or the reserved size code 3.
- R6: When req_valid is low, bank_en and align_err are zero, whatever the other request inputs hold.
- R7: On an accepted read, cpu_rdata holds the selected bank bytes right-aligned, in ascending bank order, with the upper bits zero. cpu_rdata is zero for writes, idle cycles and errors.
- R8: On an accepted write, bank lane j carries processor byte (j mod n), where n is the transfer size in bytes. bank_wdata is zero for reads, idle cycles and errors.
- R9: On an accepted I/O request (req_io = 1), io_last_port equals address + n - 1. In the same case, io_fixed_ok is 1 exactly when the address is at most 0xFF. Both outputs are zero for memory requests, idle cycles and errors.
- R10: Every output reflects the request inputs, and the bank_rdata value, that were sampled at the most recent rising clock edge. The outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port space, 0 = memory |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 16 | Byte address or port number |
| cpu_wdata | input | 32 | Processor write data, low-order aligned |
| bank_rdata | input | 32 | Read bytes from the banks, lane j on bits 8j+7..8j |
| bank_en | output | 4 | Per-bank enable |
| bank_wdata | output | 32 | Write data steered onto the bank lanes |
| cpu_rdata | output | 32 | Read data right-aligned for the processor |
| align_err | output | 1 | Misaligned or reserved-size request |
| io_last_port | output | 16 | Last consecutive byte port of an I/O access |
| io_fixed_ok | output | 1 | I/O run reachable with an 8-bit port number |

## Verification
All results come out of one register stage, so every output is due one rising edge after its request is applied. The bench drives the inputs at the falling edge. It compares the outputs at the next falling edge, after exactly one rising edge, against values computed from the requirements. One extra check samples the outputs before that edge arrives, to confirm they still show the previous request.

// File: rtl/lane_sel_pkg.sv
package lane_sel_pkg;

    localparam int ADDR_W    = 16;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int DATA_W    = LANES * LANE_W;
    localparam int OFS_W     = $clog2(LANES);
    localparam int CNT_W     = OFS_W + 1;
    localparam int FIXED_W   = 8;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              io;
        xfer_size_e        size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } req_t;

    // Bytes moved by a size code; zero marks the reserved code.
    function automatic logic [CNT_W-1:0] size_bytes(xfer_size_e s);
        case (s)
            XFER_BYTE: size_bytes = CNT_W'(1);
            XFER_HALF: size_bytes = CNT_W'(2);
            XFER_WORD: size_bytes = CNT_W'(LANES);
            default:   size_bytes = '0;
        endcase
    endfunction

    // Low-address mask that must be clear for an aligned access.
    function automatic logic [OFS_W-1:0] align_mask(logic [CNT_W-1:0] n);
        logic [CNT_W-1:0] m;
        m = n - CNT_W'(1);
        align_mask = m[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_sel_pkg::*;
(
    input  logic             valid,
    input  xfer_size_e       size,
    input  logic [OFS_W-1:0] ofs,
    output logic [LANES-1:0] en,
    output logic             err,
    output logic             active,
    output logic [CNT_W-1:0] nbytes
);

    logic             misalign;
    logic [OFS_W-1:0] mask;

    always_comb begin
        nbytes   = size_bytes(size);
        mask     = align_mask(nbytes);
        misalign = (nbytes == '0) || ((ofs & mask) != '0);
        err      = valid && misalign;
        active   = valid && !misalign;
    end

    // One comparator pair per bank: inside [ofs, ofs + nbytes).
    for (genvar i = 0; i < LANES; i++) begin : g_lane_en
        logic [CNT_W:0] lo;
        logic [CNT_W:0] hi;
        assign lo    = {{(CNT_W+1-OFS_W){1'b0}}, ofs};
        assign hi    = lo + {1'b0, nbytes};
        assign en[i] = active && ((CNT_W+1)'(i) >= lo) && ((CNT_W+1)'(i) < hi);
    end

endmodule

// File: rtl/wr_steer.sv
module wr_steer
    import lane_sel_pkg::*;
(
    input  logic              drive,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [DATA_W-1:0] lane_data
);

    logic [OFS_W-1:0] mask;
    assign mask = align_mask(nbytes);

    // Lane j takes processor byte (j mod n); n is a power of two.
    for (genvar j = 0; j < LANES; j++) begin : g_wr_lane
        logic [OFS_W-1:0] src;
        assign src = OFS_W'(j) & mask;
        assign lane_data[j*LANE_W +: LANE_W] =
            drive ? cpu_data[src*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/rd_steer.sv
module rd_steer
    import lane_sel_pkg::*;
(
    input  logic              drive,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [DATA_W-1:0] bank_data,
    output logic [DATA_W-1:0] cpu_data
);

    // Processor byte k comes from bank (ofs + k) while k < n, else zero.
    for (genvar k = 0; k < LANES; k++) begin : g_rd_lane
        logic [OFS_W-1:0] src;
        logic             used;
        assign src  = ofs + OFS_W'(k);
        assign used = drive && (CNT_W'(k) < nbytes);
        assign cpu_data[k*LANE_W +: LANE_W] =
            used ? bank_data[src*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/lane_sel_top.sv
module lane_sel_top
    import lane_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic [LANES-1:0]  bank_en,
    output logic [DATA_W-1:0] bank_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              align_err,
    output logic [ADDR_W-1:0] io_last_port,
    output logic              io_fixed_ok
);

    req_t             req_q;
    logic             active;
    logic [CNT_W-1:0] nbytes;
    logic [OFS_W-1:0] ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= req_valid;
            req_q.write <= req_write;
            req_q.io    <= req_io;
            req_q.size  <= xfer_size_e'(req_size);
            req_q.addr  <= req_addr;
            req_q.wdata <= cpu_wdata;
            req_q.rdata <= bank_rdata;
        end
    end

    assign ofs = req_q.addr[OFS_W-1:0];

    lane_decode u_decode (
        .valid  (req_q.valid),
        .size   (req_q.size),
        .ofs    (ofs),
        .en     (bank_en),
        .err    (align_err),
        .active (active),
        .nbytes (nbytes)
    );

    wr_steer u_wr (
        .drive     (active && req_q.write),
        .nbytes    (nbytes),
        .cpu_data  (req_q.wdata),
        .lane_data (bank_wdata)
    );

    rd_steer u_rd (
        .drive     (active && !req_q.write),
        .ofs       (ofs),
        .nbytes    (nbytes),
        .bank_data (req_q.rdata),
        .cpu_data  (cpu_rdata)
    );

    // Consecutive byte-port run for I/O accesses.
    always_comb begin
        if (active && req_q.io) begin
            io_last_port = req_q.addr + ADDR_W'(nbytes) - ADDR_W'(1);
            io_fixed_ok  = (req_q.addr[ADDR_W-1:FIXED_W] == '0);
        end else begin
            io_last_port = '0;
            io_fixed_ok  = 1'b0;
        end
    end

    a_r2_byte_single: assert property (@(posedge clk) disable iff (rst)
        (req_q.valid && req_q.size == XFER_BYTE) |-> $onehot(bank_en));

    a_r3_half_pair: assert property (@(posedge clk) disable iff (rst)
        (req_q.valid && req_q.size == XFER_HALF && !align_err) |-> ($countones(bank_en) == 2));

    a_r4_word_all: assert property (@(posedge clk) disable iff (rst)
        (req_q.valid && req_q.size == XFER_WORD && !align_err) |-> (bank_en == '1));

    a_r5_err_no_bank: assert property (@(posedge clk) disable iff (rst)
        align_err |-> (bank_en == '0 && bank_wdata == '0 && cpu_rdata == '0));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_q.valid |-> (bank_en == '0 && !align_err));

    a_r9_mem_no_port: assert property (@(posedge clk) disable iff (rst)
        !req_q.io |-> (io_last_port == '0 && !io_fixed_ok));

endmodule

// File: tb/lane_sel_top_tb.sv
module lane_sel_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_io;
    logic [1:0]  req_size;
    logic [15:0] req_addr;
    logic [31:0] cpu_wdata, bank_rdata;
    logic [3:0]  bank_en;
    logic [31:0] bank_wdata, cpu_rdata;
    logic        align_err;
    logic [15:0] io_last_port;
    logic        io_fixed_ok;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lane_sel_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_size(req_size), .req_addr(req_addr),
        .cpu_wdata(cpu_wdata), .bank_rdata(bank_rdata), .bank_en(bank_en),
        .bank_wdata(bank_wdata), .cpu_rdata(cpu_rdata), .align_err(align_err),
        .io_last_port(io_last_port), .io_fixed_ok(io_fixed_ok)
    );

    // Reference model, written from the requirements.
    function automatic bit m_err(bit v, logic [1:0] s, logic [15:0] a);
        return v && (s == 2'd3 || (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 2'd0));
    endfunction

    function automatic logic [3:0] m_en(bit v, logic [1:0] s, logic [15:0] a);
        if (!v || m_err(v, s, a)) return 4'h0;
        case (s)
            2'd0:    return 4'b0001 << a[1:0];
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [31:0] m_rd(bit v, bit w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
        if (!v || w || m_err(v, s, a)) return 32'h0;
        case (s)
            2'd0:    return {24'h0, d[a[1:0]*8 +: 8]};
            2'd1:    return {16'h0, d[a[1:0]*8 +: 16]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] m_wd(bit v, bit w, logic [1:0] s, logic [15:0] a, logic [31:0] d);
        if (!v || !w || m_err(v, s, a)) return 32'h0;
        case (s)
            2'd0:    return {4{d[7:0]}};
            2'd1:    return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [15:0] m_last(bit v, bit io, logic [1:0] s, logic [15:0] a);
        if (!v || !io || m_err(v, s, a)) return 16'h0;
        return a + (16'd1 << s) - 16'd1;
    endfunction

    function automatic bit m_fixed(bit v, bit io, logic [1:0] s, logic [15:0] a);
        return v && io && !m_err(v, s, a) && (a <= 16'h00FF);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(bit v, bit w, bit io, logic [1:0] s, logic [15:0] a,
                         logic [31:0] wd, logic [31:0] rd);
        req_valid = v; req_write = w; req_io = io; req_size = s;
        req_addr = a; cpu_wdata = wd; bank_rdata = rd;
    endtask

    // Apply at a falling edge, check at the next falling edge (one rising edge).
    task automatic xfer(string tag, bit v, bit w, bit io, logic [1:0] s,
                        logic [15:0] a, logic [31:0] wd, logic [31:0] rd);
        drive(v, w, io, s, a, wd, rd);
        @(negedge clk);
        check({tag, " en"},   {28'h0, bank_en},     {28'h0, m_en(v, s, a)});
        check({tag, " err"},  {31'h0, align_err},   {31'h0, m_err(v, s, a)});
        check({tag, " rd"},   cpu_rdata,            m_rd(v, w, s, a, rd));
        check({tag, " wd"},   bank_wdata,           m_wd(v, w, s, a, wd));
        check({tag, " last"}, {16'h0, io_last_port}, {16'h0, m_last(v, io, s, a)});
        check({tag, " fix"},  {31'h0, io_fixed_ok}, {31'h0, m_fixed(v, io, s, a)});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst = 1'b1;
        drive(1, 1, 1, 2'd2, 16'h0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset even with a live request on the inputs
        check("R1 en",  {28'h0, bank_en}, 32'h0);
        check("R1 wd",  bank_wdata, 32'h0);
        check("R1 rd",  cpu_rdata, 32'h0);
        check("R1 err", {31'h0, align_err}, 32'h0);
        check("R1 io",  {15'h0, io_last_port, io_fixed_ok}, 32'h0);
        drive(0, 0, 0, 2'd0, 16'h0, 32'h0, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post", {28'h0, bank_en}, 32'h0);

        // R2: each byte lane
        for (int i = 0; i < 4; i++)
            xfer("R2 byte", 1, 0, 0, 2'd0, 16'h1230 + 16'(i), 32'h0, 32'hA1B2C3D4);
        // R3: halfword at both legal offsets
        xfer("R3 half0", 1, 0, 0, 2'd1, 16'h0040, 32'h0, 32'h11223344);
        xfer("R3 half2", 1, 1, 0, 2'd1, 16'h0042, 32'hDEADBEEF, 32'h0);
        // R4: word
        xfer("R4 word", 1, 0, 0, 2'd2, 16'h0080, 32'h0, 32'hCAFEF00D);
        // R5: misaligned and reserved
        xfer("R5 half odd",  1, 0, 0, 2'd1, 16'h0043, 32'h0, 32'h55667788);
        xfer("R5 word ofs2", 1, 1, 1, 2'd2, 16'h0006, 32'h12345678, 32'h0);
        xfer("R5 rsvd",      1, 0, 1, 2'd3, 16'h0000, 32'h0, 32'hFFFFFFFF);
        // R6: idle with busy inputs
        xfer("R6 idle", 0, 1, 1, 2'd2, 16'h0000, 32'hFFFFFFFF, 32'hFFFFFFFF);
        // R7: read right-alignment from an upper lane
        xfer("R7 rd byte3", 1, 0, 0, 2'd0, 16'h0003, 32'h0, 32'h9A000000);
        // R8: write replication
        xfer("R8 wr byte", 1, 1, 0, 2'd0, 16'h0001, 32'h000000C5, 32'h0);
        // R9: port runs at the fixed-form boundary
        xfer("R9 io word FC",  1, 0, 1, 2'd2, 16'h00FC, 32'h0, 32'h01020304);
        xfer("R9 io half FE",  1, 1, 1, 2'd1, 16'h00FE, 32'hABCD, 32'h0);
        xfer("R9 io byte 100", 1, 0, 1, 2'd0, 16'h0100, 32'h0, 32'h000000EE);

        // R10: outputs hold the last sampled request until the next rising edge
        drive(1, 0, 0, 2'd2, 16'h0000, 32'h0, 32'h0);
        #5;
        check("R10 hold", {28'h0, bank_en}, 32'h1);
        @(negedge clk);
        check("R10 update", {28'h0, bank_en}, 32'hF);

        // Random mix covering R2..R9
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic [1:0]  s;
            a = 16'($urandom);
            s = 2'($urandom);
            if ($urandom_range(0, 3) != 0) begin
                if (s == 2'd1) a[0] = 1'b0;
                if (s == 2'd2) a[1:0] = 2'b00;
            end
            if ($urandom_range(0, 1) == 0) a[15:8] = 8'h00;
            xfer("R2-9 random", ($urandom_range(0, 9) != 0), 1'($urandom), 1'($urandom),
                 s, a, $urandom, $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule